// File: doc/BRIEF.md
# Time-Shared Wavetable Oscillator Bank

This block runs a large set of wavetable oscillators on a single phase adder and one read port into external sample memory. Each oscillator (a voice) keeps a phase word, a frequency step and a bank number. A frame-start pulse makes the sequencer visit every voice once, in ascending order. On each visit the sequencer does four things. It forms a memory address from the voice's bank number and the top bits of its phase. It issues one read. It advances the stored phase by the step. It tags the read with the voice number.

The memory returns a word a fixed number of cycles after each read. The block puts the word and its voice tag into a small queue. The queue feeds an output stream with a valid/ready handshake. When the consumer stalls, the sequencer stops issuing reads once the queue and the reads in flight fill the available credit. No sample is lost.

A host write port sets a voice's step or its bank. Each table bank holds one full waveform cycle, so the upper phase bits index straight into it.

Top module: `wt_osc_bank`

## Requirements
- R1: After reset, out_valid and mem_rd are 0, and every voice's phase, step and bank are zero. The first frame therefore reads address {bank, 12'h000} for every voice.
- R2: Each frame_start pulse makes the block issue exactly N_VOICES reads. The samples leave in voice order 0, 1, …, N_VOICES-1. After that, mem_rd and out_valid stay low until the next pulse.
- R3: The read address is the voice's 8-bit bank in bits [19:12], with phase bits [23:12] in bits [11:0].
- R4: After each visit, a voice's phase grows by its step, modulo 2^24. An overflow wraps with no indication.
- R5: Each output carries the memory word that returned MEM_LAT cycles after its read, paired with the voice number of that read.
- R6: While out_valid is high and out_ready is low, out_sample and out_voice hold steady. Reads stop once MEM_LAT+1 results are outstanding. No sample is dropped or duplicated when the stream resumes.
- R7: A host write with host_sel 0 sets a voice's step. A write with host_sel 1 sets its bank from host_wdata[7:0]. The new value is used from the voice's next visit onward. A write that lands in the same cycle as that voice's read leaves the current visit on the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a new pass over all voices |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the step, 1 selects the bank |
| host_voice | input | 8 | Voice being written |
| host_wdata | input | 24 | Write data |
| mem_rd | output | 1 | Read request to sample memory |
| mem_addr | output | 20 | Sample memory address |
| mem_rdata | input | 16 | Read data, valid MEM_LAT cycles after the request |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | 16 | Sample word |
| out_voice | output | 8 | Voice the sample belongs to |

## Verification
Two events can fall in the same cycle: a host write to a voice, and that voice's own read slot. The bench counts issued reads within a frame, so it knows which cycle services voice 50. It raises the step write to that voice in exactly that cycle. It then expects the following frame to show the old step's phase and the frame after to show the new one. Backpressure is provoked separately with a long ready-low stall and a pseudo-random ready pattern. Every accepted sample is compared against a bench model of phase, step and bank.

// File: rtl/wt_osc_pkg.sv
package wt_osc_pkg;
   typedef enum logic {SEL_STEP = 1'b0, SEL_BANK = 1'b1} host_sel_e;
endpackage

// File: rtl/wt_voice_table.sv
module wt_voice_table
   import wt_osc_pkg::*;
#(
   parameter int N_VOICES = 256,
   parameter int VOICE_W  = 8,
   parameter int PHASE_W  = 24,
   parameter int BANK_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [VOICE_W-1:0] wr_voice,
   input  logic [PHASE_W-1:0] wr_data,
   input  logic [VOICE_W-1:0] rd_voice,
   output logic [PHASE_W-1:0] rd_step,
   output logic [BANK_W-1:0]  rd_bank
);
   logic [PHASE_W-1:0] step_q [N_VOICES];
   logic [BANK_W-1:0]  bank_q [N_VOICES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_VOICES; i++) begin
            step_q[i] <= '0;
            bank_q[i] <= '0;
         end
      end else if (wr_en) begin
         if (host_sel_e'(wr_sel) == SEL_BANK) bank_q[wr_voice] <= wr_data[BANK_W-1:0];
         else                                  step_q[wr_voice] <= wr_data;
      end
   end

   // read is combinational: a write on the slot's edge is seen next visit (R7)
   assign rd_step = step_q[rd_voice];
   assign rd_bank = bank_q[rd_voice];
endmodule

// File: rtl/wt_phase_seq.sv
module wt_phase_seq #(
   parameter int N_VOICES = 256,
   parameter int VOICE_W  = 8,
   parameter int PHASE_W  = 24,
   parameter int BANK_W   = 8,
   parameter int TBL_BITS = 12,
   localparam int ADDR_W  = BANK_W + TBL_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               can_issue,
   input  logic [PHASE_W-1:0] step,
   input  logic [BANK_W-1:0]  bank,
   output logic [VOICE_W-1:0] cur_voice,
   output logic               issue,
   output logic [ADDR_W-1:0]  addr
);
   localparam logic [VOICE_W-1:0] LAST = VOICE_W'(N_VOICES - 1);

   logic               running;
   logic [VOICE_W-1:0] vcnt;
   logic [PHASE_W-1:0] phase_q [N_VOICES];

   assign cur_voice = vcnt;
   assign issue     = running && can_issue;
   assign addr      = {bank, phase_q[vcnt][PHASE_W-1 -: TBL_BITS]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         vcnt    <= '0;
         for (int i = 0; i < N_VOICES; i++) phase_q[i] <= '0;
      end else begin
         if (issue) phase_q[vcnt] <= phase_q[vcnt] + step;
         if (frame_start) begin
            running <= 1'b1;
            vcnt    <= '0;
         end else if (issue) begin
            if (vcnt == LAST) running <= 1'b0;
            else              vcnt    <= vcnt + 1'b1;
         end
      end
   end

   AST_VOICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !frame_start && vcnt != LAST) |=> (vcnt == $past(vcnt) + 1'b1)); // R2
endmodule

// File: rtl/wt_tag_pipe.sv
module wt_tag_pipe #(
   parameter int VOICE_W  = 8,
   parameter int SAMPLE_W = 16,
   parameter int MEM_LAT  = 2,
   localparam int DEPTH   = MEM_LAT + 1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue,
   input  logic [VOICE_W-1:0]  issue_voice,
   input  logic [SAMPLE_W-1:0] mem_rdata,
   input  logic                out_ready,
   output logic                can_issue,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic [VOICE_W-1:0]  out_voice
);
   localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

   logic [MEM_LAT-1:0] vld_sr;
   logic [VOICE_W-1:0] tag_sr [MEM_LAT];

   generate
      if (MEM_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_sr    <= '0;
               tag_sr[0] <= '0;
            end else begin
               vld_sr[0] <= issue;
               tag_sr[0] <= issue_voice;
            end
         end
      end else begin : g_lat_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_sr <= '0;
               for (int i = 0; i < MEM_LAT; i++) tag_sr[i] <= '0;
            end else begin
               vld_sr    <= {vld_sr[MEM_LAT-2:0], issue};
               tag_sr[0] <= issue_voice;
               for (int i = 1; i < MEM_LAT; i++) tag_sr[i] <= tag_sr[i-1];
            end
         end
      end
   endgenerate

   logic                push, pop;
   logic [SAMPLE_W-1:0] smp_q [DEPTH];
   logic [VOICE_W-1:0]  vox_q [DEPTH];
   logic [PTR_W-1:0]    wr_ptr, rd_ptr;
   logic [CNT_W-1:0]    cnt_q, credit_q;

   assign push       = vld_sr[MEM_LAT-1];
   assign out_valid  = (cnt_q != '0);
   assign pop        = out_valid && out_ready;
   assign out_sample = smp_q[rd_ptr];
   assign out_voice  = vox_q[rd_ptr];
   assign can_issue  = (credit_q < FULL) || pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         cnt_q    <= '0;
         credit_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            smp_q[i] <= '0;
            vox_q[i] <= '0;
         end
      end else begin
         if (push) begin
            smp_q[wr_ptr] <= mem_rdata;
            vox_q[wr_ptr] <= tag_sr[MEM_LAT-1];
            wr_ptr        <= (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         case ({issue, pop})
            2'b10:   credit_q <= credit_q + 1'b1;
            2'b01:   credit_q <= credit_q - 1'b1;
            default: credit_q <= credit_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < FULL || pop)); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_voice))); // R6
   AST_VALID_FROM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(push)); // R5
endmodule

// File: rtl/wt_osc_bank.sv
module wt_osc_bank
   import wt_osc_pkg::*;
#(
   parameter int N_VOICES = 256,
   parameter int PHASE_W  = 24,
   parameter int BANK_W   = 8,
   parameter int TBL_BITS = 12,
   parameter int SAMPLE_W = 16,
   parameter int MEM_LAT  = 2,
   localparam int VOICE_W = $clog2(N_VOICES),
   localparam int ADDR_W  = BANK_W + TBL_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic                host_we,
   input  logic                host_sel,
   input  logic [VOICE_W-1:0]  host_voice,
   input  logic [PHASE_W-1:0]  host_wdata,
   output logic                mem_rd,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic [SAMPLE_W-1:0] mem_rdata,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic [VOICE_W-1:0]  out_voice
);
   generate
      if (TBL_BITS > PHASE_W) begin : g_bad_tbl
         $error("TBL_BITS must not exceed PHASE_W");
      end
      if (BANK_W > PHASE_W) begin : g_bad_bank
         $error("BANK_W must fit in the host write word");
      end
      if (MEM_LAT < 1) begin : g_bad_lat
         $error("MEM_LAT must be at least 1");
      end
      if (N_VOICES < 2) begin : g_bad_voices
         $error("N_VOICES must be at least 2");
      end
   endgenerate

   logic [VOICE_W-1:0] cur_voice;
   logic [PHASE_W-1:0] step;
   logic [BANK_W-1:0]  bank;
   logic               issue, can_issue;

   wt_voice_table #(
      .N_VOICES(N_VOICES), .VOICE_W(VOICE_W), .PHASE_W(PHASE_W), .BANK_W(BANK_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_we), .wr_sel(host_sel), .wr_voice(host_voice), .wr_data(host_wdata),
      .rd_voice(cur_voice), .rd_step(step), .rd_bank(bank)
   );

   wt_phase_seq #(
      .N_VOICES(N_VOICES), .VOICE_W(VOICE_W), .PHASE_W(PHASE_W),
      .BANK_W(BANK_W), .TBL_BITS(TBL_BITS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .can_issue(can_issue),
      .step(step), .bank(bank), .cur_voice(cur_voice), .issue(issue), .addr(mem_addr)
   );

   wt_tag_pipe #(
      .VOICE_W(VOICE_W), .SAMPLE_W(SAMPLE_W), .MEM_LAT(MEM_LAT)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_voice(cur_voice),
      .mem_rdata(mem_rdata), .out_ready(out_ready), .can_issue(can_issue),
      .out_valid(out_valid), .out_sample(out_sample), .out_voice(out_voice)
   );

   assign mem_rd = issue;
endmodule

// File: tb/wt_osc_bank_tb.sv
`timescale 1ns/1ps
module wt_osc_bank_tb;
   localparam int MEM_LAT = 2;
   localparam int NV      = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        host_we = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_voice = '0;
   logic [23:0] host_wdata = '0;
   logic        mem_rd;
   logic [19:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_sample;
   logic [7:0]  out_voice;

   always #2 clk = ~clk;

   wt_osc_bank u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .host_we(host_we), .host_sel(host_sel), .host_voice(host_voice), .host_wdata(host_wdata),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample), .out_voice(out_voice)
   );

   function automatic logic [15:0] memf(input logic [19:0] a);
      return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]};
   endfunction

   // external memory model with fixed latency
   logic [15:0] mpipe [MEM_LAT];
   always @(posedge clk) begin
      mpipe[0] <= mem_rd ? memf(mem_addr) : 16'h0000;
      for (int i = 1; i < MEM_LAT; i++) mpipe[i] <= mpipe[i-1];
   end
   assign mem_rdata = mpipe[MEM_LAT-1];

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bench model
   logic [23:0] m_phase [NV];
   logic [23:0] m_step  [NV];
   logic [7:0]  m_bank  [NV];
   logic [15:0] got     [NV];
   logic [7:0]  exp_v = '0;
   int          n_out = 0;
   bit          pend_v = 0;
   logic [7:0]  pend_voice = '0;
   logic [23:0] pend_step = '0;
   int          n_rd_frame = 0;

   initial begin
      for (int i = 0; i < NV; i++) begin
         m_phase[i] = '0; m_step[i] = '0; m_bank[i] = '0; got[i] = '0;
      end
   end

   always @(posedge clk) begin
      if (frame_start)  n_rd_frame <= 0;
      else if (mem_rd)  n_rd_frame <= n_rd_frame + 1;
   end

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin : mon
         logic [19:0] a;
         a = {m_bank[exp_v], m_phase[exp_v][23:12]};
         chk(out_voice == exp_v, "R2 voice order", {24'h0, out_voice}, {24'h0, exp_v});
         chk(out_sample == memf(a), "R3/R5 sample for address", {16'h0, out_sample}, {16'h0, memf(a)});
         got[exp_v] = out_sample;
         m_phase[exp_v] = m_phase[exp_v] + m_step[exp_v];
         if (pend_v && pend_voice == exp_v) begin
            m_step[exp_v] = pend_step;
            pend_v = 0;
         end
         exp_v = exp_v + 8'd1;
         n_out++;
      end
   end

   // {voice, step, bank, expected frame-2 address}
   localparam logic [59:0] VEC [8] = '{
      {8'h00, 24'h001000, 8'h03, 20'h03001},
      {8'h01, 24'h123456, 8'hA5, 20'hA5123},
      {8'h07, 24'hFFF000, 8'h10, 20'h10FFF},
      {8'h64, 24'h800000, 8'hFF, 20'hFF800},
      {8'hC8, 24'h000FFF, 8'h01, 20'h01000},
      {8'hFF, 24'h654321, 8'h7E, 20'h7E654},
      {8'h80, 24'h000000, 8'h40, 20'h40000},
      {8'h1F, 24'hABCDEF, 8'h00, 20'h00ABC}
   };

   task automatic host_write(input logic sel, input logic [7:0] v, input logic [23:0] d);
      @(posedge clk); #1;
      host_we = 1'b1; host_sel = sel; host_voice = v; host_wdata = d;
      @(posedge clk); #1;
      host_we = 1'b0;
   endtask

   task automatic start_frame();
      @(posedge clk); #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
   endtask

   task automatic wait_outs(input int target);
      int t = 0;
      while (n_out < target && t < 20000) begin
         @(posedge clk); #1;
         t++;
      end
      if (n_out < target) chk(1'b0, "R2 frame completes", n_out, target);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 reset out_valid", {31'h0, out_valid}, 0);
      chk(mem_rd == 1'b0, "R1 reset mem_rd", {31'h0, mem_rd}, 0);
      rst_n = 1'b1;

      // table-driven programming (R7: sel 0 step, sel 1 bank)
      foreach (VEC[i]) begin
         host_write(1'b0, VEC[i][59:52], VEC[i][51:28]);
         host_write(1'b1, VEC[i][59:52], {16'h0, VEC[i][27:20]});
         m_step[VEC[i][59:52]] = VEC[i][51:28];
         m_bank[VEC[i][59:52]] = VEC[i][27:20];
      end

      // frame 1: phases all zero (R1)
      start_frame();
      wait_outs(NV);
      repeat (10) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R2 idle after frame valid", {31'h0, out_valid}, 0);
      chk(mem_rd == 1'b0, "R2 idle after frame read", {31'h0, mem_rd}, 0);
      chk(n_out == NV, "R2 exactly one pass", n_out, NV);
      chk(got[0] == memf(20'h03000), "R1 zero phase first frame", {16'h0, got[0]}, {16'h0, memf(20'h03000)});

      // frame 2: check table expectations (R3, R4)
      start_frame();
      wait_outs(2 * NV);
      foreach (VEC[i]) begin
         chk(got[VEC[i][59:52]] == memf(VEC[i][19:0]), "R3/R4 table vector",
             {16'h0, got[VEC[i][59:52]]}, {16'h0, memf(VEC[i][19:0])});
      end

      // frame 3: long stall then random ready (R6), wrap (R4)
      start_frame();
      wait_outs(2 * NV + 40);
      out_ready = 1'b0;
      repeat (12) @(posedge clk);
      #1;
      chk(mem_rd == 1'b0, "R6 reads halt under stall", {31'h0, mem_rd}, 0);
      chk(out_valid == 1'b1, "R6 valid held under stall", {31'h0, out_valid}, 1);
      begin
         logic [7:0]  hv;
         logic [15:0] hs;
         hv = out_voice; hs = out_sample;
         repeat (5) @(posedge clk);
         #1;
         chk(out_voice == hv, "R6 voice stable under stall", {24'h0, out_voice}, {24'h0, hv});
         chk(out_sample == hs, "R6 sample stable under stall", {16'h0, out_sample}, {16'h0, hs});
      end
      begin
         logic [7:0] lfsr;
         int t;
         lfsr = 8'hB7; t = 0;
         while (n_out < 3 * NV && t < 20000) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0];
            @(posedge clk); #1;
            t++;
         end
      end
      out_ready = 1'b1;
      wait_outs(3 * NV);
      chk(got[8'h64] == memf(20'hFF000), "R4 phase wraps", {16'h0, got[8'h64]}, {16'h0, memf(20'hFF000)});
      repeat (10) @(posedge clk);
      #1;
      chk(n_out == 3 * NV, "R6 no duplicate after stall", n_out, 3 * NV);

      // frame 4: step write in the same cycle as voice 50's read (R7)
      start_frame();
      begin
         int t = 0;
         while (!(mem_rd && n_rd_frame == 50) && t < 1000) begin
            @(posedge clk); #1;
            t++;
         end
      end
      host_we = 1'b1; host_sel = 1'b0; host_voice = 8'd50; host_wdata = 24'h100000;
      pend_voice = 8'd50; pend_step = 24'h100000; pend_v = 1;
      @(posedge clk); #1;
      host_we = 1'b0;
      wait_outs(4 * NV);
      chk(got[50] == memf(20'h00000), "R7 frame of write uses old", {16'h0, got[50]}, {16'h0, memf(20'h00000)});
      start_frame();
      wait_outs(5 * NV);
      chk(got[50] == memf(20'h00000), "R7 same-slot write deferred", {16'h0, got[50]}, {16'h0, memf(20'h00000)});
      start_frame();
      wait_outs(6 * NV);
      chk(got[50] == memf(20'h00100), "R7 new step in effect", {16'h0, got[50]}, {16'h0, memf(20'h00100)});

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule